// File: doc/BRIEF.md
# CORDIC NCO Frequency Mixer

This block moves a complex baseband stream up or down in frequency. A numerically controlled oscillator steps a 32-bit phase register once per clock by a programmable signed step. Each accepted I/Q sample is turned through the oscillator's phase at the moment it enters. The turn is done by a pipelined CORDIC in rotation mode. A coarse quadrant stage first brings the angle into the range where the iterations converge, and a chain of shift-and-add stages follows it. The pipeline takes one new sample every clock.

Software or a control FSM sets the tuning by writing the phase step. A step of k moves the signal by k·fclk/2^32. Negative steps tune below zero, and a step of zero leaves the signal at DC. The CORDIC gain (about 1.6468) is not removed. Two guard bits absorb that gain, and the output drops those two bits. The overall gain is therefore about 0.4117.

Both sample interfaces use valid/ready. A sample is taken on a clock edge where `s_valid` and `s_ready` are both high. A result leaves on an edge where `m_valid` and `m_ready` are both high. While a result waits with `m_ready` low, the whole pipeline freezes and `s_ready` stays low. The phase register keeps running during a stall, because it keeps time and is not part of the data path.

Top module: `nco_mixer`

## Requirements
- R1: The phase register is 32 bits wide, clears to 0 on reset and adds the phase step on every clock, wrapping modulo 2^32. A step written with `inc_wr` high at one edge is first added at the following edge.
- R2: The phase step is read as two's complement. A positive step rotates counter-clockwise (multiplies by e^{+jθ}), a negative step rotates clockwise, and 0x80000000 rotates by π per clock.
- R3: The rotation angle of a sample is the upper 14 bits of the phase register value held at the edge where the sample is accepted. A full turn is 2^14 of these units, so the lower 18 bits have no effect on the result.
- R4: `m_i`/`m_q` equal (K/4)·(I·cosθ − Q·sinθ) and (K/4)·(I·sinθ + Q·cosθ) within ±24 LSB, with K = 1.64676. This holds across the full 16-bit input range, including −32768.
- R5: With a zero phase step after reset, every output equals K/4 times its input within the R4 tolerance.
- R6: With `m_ready` held high, a sample accepted at one edge appears on `m_valid` exactly 13 clocks later (one quadrant stage plus 12 iterations). Results leave in input order, one per clock, and no result appears without an input.
- R7: `s_ready` is high whenever `m_valid` is low or `m_ready` is high. While `m_valid` is high and `m_ready` is low, `s_ready` is low and `m_valid`, `m_i` and `m_q` hold their values.
- R8: The angle left over after the last iteration stays within twice the last arctangent step plus 12 units of 2^-18 turn. This keeps the rotation error inside the R4 bound.
- R9: During and right after reset, `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_wr | input | 1 | Write strobe for the phase step |
| inc_data | input | 32 | New phase step, two's complement |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take an input sample |
| s_i | input | 16 | Input in-phase sample, signed |
| s_q | input | 16 | Input quadrature sample, signed |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream takes the output sample |
| m_i | output | 16 | Rotated in-phase sample, signed |
| m_q | output | 16 | Rotated quadrature sample, signed |

## Verification
A fault in the phase register shows up at once as the wrong rotation angle on every later output. The angle error grows steadily with time, so a wrong step or a wrong write timing is visible within a few samples of a step change. A wrong quadrant choice or arctangent constant gives an output error of hundreds to thousands of LSB, 13 clocks after the affected sample enters. A wrong valid shift or stall enable shows as a changed latency, a lost or duplicated result, or output data that moves while `m_ready` is low.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  // Internal angle scale: one full turn equals 2^ZTURN_W units.
  localparam int ZTURN_W = 18;

  // Rounded arctan(2^-idx) expressed in units of 2^-ZTURN_W turn.
  function automatic logic [ZTURN_W-1:0] atan_turn(input int idx);
    case (idx)
      0:       return 18'd32768;
      1:       return 18'd19344;
      2:       return 18'd10221;
      3:       return 18'd5188;
      4:       return 18'd2604;
      5:       return 18'd1303;
      6:       return 18'd652;
      7:       return 18'd326;
      8:       return 18'd163;
      9:       return 18'd81;
      10:      return 18'd41;
      11:      return 18'd20;
      12:      return 18'd10;
      13:      return 18'd5;
      14:      return 18'd3;
      15:      return 18'd1;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ACC_W-1:0] wr_inc,
  output logic [ACC_W-1:0] phase
);

  logic [ACC_W-1:0] step_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      step_q <= '0;
    end else begin
      phase <= phase + step_q;
      if (wr_en) step_q <= wr_inc;
    end
  end

  // Saturating count of edges since reset, used to bound $past history.
  always_ff @(posedge clk) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R1: with no write in the two previous cycles the phase moves by a constant step.
  a_r1_uniform_step: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(wr_en) && !$past(wr_en, 2)) |->
      ((phase - $past(phase)) == ($past(phase) - $past(phase, 2))));

endmodule

// File: rtl/nco_prerot.sv
module nco_prerot #(
  parameter int IW       = 16,
  parameter int DW       = 18,
  parameter int ANG_BITS = 14,
  parameter int ZW       = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  input  logic [ANG_BITS-1:0]  ang,
  output logic                 v_out,
  output logic signed [DW-1:0] x_out,
  output logic signed [DW-1:0] y_out,
  output logic signed [ZW-1:0] z_out
);
  import nco_mix_pkg::*;

  localparam int GUARD = DW - IW;
  localparam int SH    = ZTURN_W - ANG_BITS;
  localparam logic [ANG_BITS-1:0] EIGHTH = ANG_BITS'(1) << (ANG_BITS - 3);

  logic [ANG_BITS-1:0] ang_ctr;
  logic [1:0]          quad;
  logic [ANG_BITS-1:0] rem_u;
  logic signed [ZW-1:0] z_n;
  logic signed [DW-1:0] xi, yi, x_n, y_n;

  always_comb begin
    // Pick the nearest multiple of 90 degrees; the remainder is in [-45, +45).
    ang_ctr = ang + EIGHTH;
    quad    = ang_ctr[ANG_BITS-1 -: 2];
    rem_u   = ang - {quad, {(ANG_BITS-2){1'b0}}};
    z_n     = {{(ZW-ANG_BITS){rem_u[ANG_BITS-1]}}, rem_u} << SH;
    xi      = {{GUARD{in_i[IW-1]}}, in_i};
    yi      = {{GUARD{in_q[IW-1]}}, in_q};
    case (quad)
      2'd0:    begin x_n = xi;  y_n = yi;  end
      2'd1:    begin x_n = -yi; y_n = xi;  end
      2'd2:    begin x_n = -xi; y_n = -yi; end
      default: begin x_n = yi;  y_n = -xi; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else if (adv) begin
      v_out <= in_valid;
      x_out <= x_n;
      y_out <= y_n;
      z_out <= z_n;
    end
  end

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int DW  = 18,
  parameter int ZW  = 19,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 v_in,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic signed [ZW-1:0] z_in,
  output logic                 v_out,
  output logic signed [DW-1:0] x_out,
  output logic signed [DW-1:0] y_out,
  output logic signed [ZW-1:0] z_out
);
  import nco_mix_pkg::*;

  localparam logic signed [ZW-1:0] STEP = ZW'(atan_turn(IDX));

  logic signed [DW-1:0] xs, ys, x_n, y_n;
  logic signed [ZW-1:0] z_n;

  always_comb begin
    xs = x_in >>> IDX;
    ys = y_in >>> IDX;
    if (!z_in[ZW-1]) begin
      x_n = x_in - ys;
      y_n = y_in + xs;
      z_n = z_in - STEP;
    end else begin
      x_n = x_in + ys;
      y_n = y_in - xs;
      z_n = z_in + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      x_out <= '0;
      y_out <= '0;
      z_out <= '0;
    end else if (adv) begin
      v_out <= v_in;
      x_out <= x_n;
      y_out <= y_n;
      z_out <= z_n;
    end
  end

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int IN_W     = 16,
  parameter int ACC_W    = 32,
  parameter int ANG_BITS = 14,
  parameter int ITER     = 12,
  parameter int GUARD    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inc_wr,
  input  logic [ACC_W-1:0]       inc_data,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic signed [IN_W-1:0] s_i,
  input  logic signed [IN_W-1:0] s_q,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic signed [IN_W-1:0] m_i,
  output logic signed [IN_W-1:0] m_q
);
  import nco_mix_pkg::*;

  localparam int DW     = IN_W + GUARD;
  localparam int ZW     = ZTURN_W + 1;
  localparam int ZBOUND = 2 * int'(atan_turn(ITER - 1)) + ITER;

  logic [ACC_W-1:0]     phase;
  logic                 adv;
  logic                 v_p [0:ITER];
  logic signed [DW-1:0] x_p [0:ITER];
  logic signed [DW-1:0] y_p [0:ITER];
  logic signed [ZW-1:0] z_p [0:ITER];
  logic signed [ZW-1:0] z_abs;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (inc_wr),
    .wr_inc (inc_data),
    .phase  (phase)
  );

  // Global stall: the pipeline moves only when the last slot is free or leaving.
  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;

  nco_prerot #(.IW(IN_W), .DW(DW), .ANG_BITS(ANG_BITS), .ZW(ZW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_valid (s_valid),
    .in_i     (s_i),
    .in_q     (s_q),
    .ang      (phase[ACC_W-1 -: ANG_BITS]),
    .v_out    (v_p[0]),
    .x_out    (x_p[0]),
    .y_out    (y_p[0]),
    .z_out    (z_p[0])
  );

  for (genvar k = 0; k < ITER; k++) begin : g_iter
    nco_cordic_stage #(.DW(DW), .ZW(ZW), .IDX(k)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v_in  (v_p[k]),
      .x_in  (x_p[k]),
      .y_in  (y_p[k]),
      .z_in  (z_p[k]),
      .v_out (v_p[k+1]),
      .x_out (x_p[k+1]),
      .y_out (y_p[k+1]),
      .z_out (z_p[k+1])
    );
  end

  assign m_valid = v_p[ITER];
  assign m_i     = x_p[ITER][DW-1 -: IN_W];
  assign m_q     = y_p[ITER][DW-1 -: IN_W];
  assign z_abs   = z_p[ITER][ZW-1] ? -z_p[ITER] : z_p[ITER];

  // R7: a held result does not move.
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q)));

  // R7: no new sample is taken while the output is blocked.
  a_r7_no_accept_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R8: residual angle after the last iteration is small.
  a_r8_residual_small: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (z_abs <= ZW'(ZBOUND)));

endmodule

// File: tb/test_nco_mixer.sv
module test_nco_mixer;

  localparam real K_GAIN = 1.6467602;
  localparam real TOL    = 24.0;
  localparam real TWO_PI = 6.283185307179586;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_wr = 1'b0;
  logic [31:0] inc_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic signed [15:0] m_i, m_q;

  int tests = 0;
  int fails = 0;
  bit running = 0;
  bit done = 0;
  string tag = "R5";

  // Reference model state
  bit [31:0] ph_m = '0, inc_m = '0;
  int  cyc = 0, stalls = 0;
  int  q_i[$], q_q[$], q_cyc[$], q_st[$];
  bit [31:0] q_ph[$];
  bit  was_stalled = 0;
  logic signed [15:0] held_i, held_q;

  always #2.5 clk = ~clk;

  nco_mixer i_nco_mixer (
    .clk(clk), .rst_n(rst_n), .inc_wr(inc_wr), .inc_data(inc_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Evaluate what the coming rising edge will do, after inputs settle.
  always @(negedge clk) begin
    #1;
    if (running) begin
      cyc++;
      if (was_stalled) begin
        check(m_valid == 1'b1, "R7", "valid dropped during stall", int'(m_valid), 1);
        check(m_i == held_i && m_q == held_q, "R7", "data moved during stall",
              int'(m_i), int'(held_i));
      end
      was_stalled = 0;
      if (m_valid && !m_ready) begin
        check(s_ready == 1'b0, "R7", "ready while blocked", int'(s_ready), 0);
        stalls++;
        was_stalled = 1;
        held_i = m_i;
        held_q = m_q;
      end
      if (!m_valid || m_ready)
        check(s_ready == 1'b1, "R7", "not ready while free", int'(s_ready), 1);
      if (m_valid && m_ready) begin
        if (q_i.size() == 0) begin
          check(0, "R6", "result without input", 1, 0);
        end else begin
          int ii, qq, c0, st0;
          bit [31:0] ph;
          real th, ei, eq;
          ii = q_i.pop_front(); qq = q_q.pop_front();
          c0 = q_cyc.pop_front(); st0 = q_st.pop_front(); ph = q_ph.pop_front();
          th = TWO_PI * real'(ph[31:18]) / 16384.0;
          ei = K_GAIN * (real'(ii) * $cos(th) - real'(qq) * $sin(th)) / 4.0;
          eq = K_GAIN * (real'(ii) * $sin(th) + real'(qq) * $cos(th)) / 4.0;
          check((real'(m_i) - ei) <= TOL && (ei - real'(m_i)) <= TOL,
                {tag, "/R4/R8"}, "I out", int'(m_i), $rtoi(ei));
          check((real'(m_q) - eq) <= TOL && (eq - real'(m_q)) <= TOL,
                {tag, "/R4/R8"}, "Q out", int'(m_q), $rtoi(eq));
          if (st0 == stalls)
            check(cyc - c0 == 13, "R6", "latency", cyc - c0, 13);
        end
      end
      if (s_valid && s_ready) begin
        q_i.push_back(int'(s_i)); q_q.push_back(int'(s_q));
        q_cyc.push_back(cyc); q_st.push_back(stalls); q_ph.push_back(ph_m);
      end
      // R1: phase adds the old step on this edge; a write lands after it.
      ph_m = ph_m + inc_m;
      if (inc_wr) inc_m = inc_data;
    end
  end

  function automatic logic signed [15:0] pick();
    int r = $urandom % 10;
    if (r == 0) return 16'sh8000;
    if (r == 1) return 16'sh7fff;
    return 16'($urandom);
  endfunction

  task automatic run(input bit wr, input bit [31:0] step, input int n,
                     input int pv, input int pr);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      inc_wr   = (c == 0) && wr;
      inc_data = step;
      s_valid  = ($urandom % 100) < pv;
      s_i      = pick();
      s_q      = pick();
      m_ready  = ($urandom % 100) < pr;
    end
    @(negedge clk);
    inc_wr = 1'b0; s_valid = 1'b0; m_ready = 1'b1;
    repeat (20) @(negedge clk);
    check(q_i.size() == 0, "R6", "results outstanding", q_i.size(), 0);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state.
    check(m_valid == 1'b0, "R9", "valid in reset", int'(m_valid), 0);
    check(s_ready == 1'b1, "R9", "ready in reset", int'(s_ready), 1);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    check(m_valid == 1'b0, "R9", "valid after reset", int'(m_valid), 0);

    tag = "R5"; run(0, 32'h0, 60, 100, 100);           // DC pass-through
    tag = "R1"; run(1, 32'h0123_4567, 200, 100, 100);  // positive tuning
    tag = "R2"; run(1, 32'hF7A1_0000, 200, 80, 100);   // negative tuning
    tag = "R2"; run(1, 32'h8000_0000, 100, 100, 100);  // half clock rate
    tag = "R3"; run(1, 32'h0000_0001, 100, 100, 100);  // sub-LSB angle steps
    tag = "R3"; run(1, 32'h0003_FFFF, 150, 100, 100);  // just under one angle unit
    tag = "R7"; run(1, 32'h1000_0ABC, 600, 70, 50);    // back-pressure
    tag = "R7"; run(1, 32'h7FFF_FFFF, 400, 100, 30);   // heavy stalls
    tag = "R1"; run(1, 32'h0456_789A, 200, 100, 100);  // write under stream
    done = 1;
    report();
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

endmodule